// File: doc/BRIEF.md
# Selectable Clock Source Router

This block steers a small set of clock sources onto the clock lines of a programmable logic fabric. Four dedicated clock pins and one clock produced inside a designated logic block are the candidate sources. Three lines feed the logic blocks and two feed the I/O cells. Each line has a fixed set of sources that the routing can reach. Pin 0 is the reference clock and is wired permanently to core line 0.

Core lines 1 and up each carry a two-bit source code, and so does every I/O line. The codes come from static configuration and are not changed while the clocks run. A code that names no reachable source turns that line off, holding it low, and raises a shared configuration error flag. The router is purely combinational, so every output follows its selected source with no register in the path. Line counts, select width and the multiplexer implementation are parameters.

Top module: `clock_route_net`

## Requirements
- R1: Core line 0 (`core_clk[0]`) equals pin 0 (`pin_clk[0]`) under every configuration.
- R2: A core line k >= 1 with source code 0 carries pin 1, with code 1 carries pin 2, and with code 2 carries `gen_clk`.
- R3: An I/O line with source code 0 carries pin 2, with code 1 carries pin 3, and with code 2 carries `gen_clk`.
- R4: Source code 3 on any selectable line holds that line at 0, whatever its candidate sources do.
- R5: `config_error` is 1 exactly when at least one core or I/O source code equals 3.
- R6: Core line k >= 1 takes its code from `core_sel[2k-1:2k-2]` and I/O line j from `io_sel[2j+1:2j]`. Each line's output depends on its own field only.
- R7: Pins 0 and 3 never reach core lines 1 and up, and pins 0 and 1 never reach any I/O line.
- R8: Outputs follow changes on the sources and selects combinationally, within the same clock phase, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pin_clk | input | 4 | Dedicated clock pins; bit 0 is the reference clock |
| gen_clk | input | 1 | Clock built inside the designated logic block |
| core_sel | input | 4 | Two-bit source codes for core lines 1 and 2 |
| io_sel | input | 4 | Two-bit source codes for I/O lines 0 and 1 |
| core_clk | output | 3 | Logic-block clock lines; bit 0 is hardwired to pin 0 |
| io_clk | output | 2 | I/O-cell clock lines |
| config_error | output | 1 | Set while any line holds the unused code 3 |

## Verification
Every one of the 256 select settings is paired with all 32 levels of the five sources, so each line is exercised with every code and every source level. This exposes several kinds of fault:
- A swapped candidate order would put the wrong pin on a line.
- A field taken from the wrong select bits would make one line follow another line's code.
- A line left floating or passing a source under code 3 would fail the dead-line and error-flag comparisons.

Directed cases cover the remaining behaviour:
- The forbidden pins are toggled while the legal candidates are held low. A router that leaked pin 3 onto a core line, or pin 1 onto an I/O line, would show a high output there.
- Inputs are changed mid-phase to show that no register sits in the path.

// File: rtl/clkroute_pkg.sv
package clkroute_pkg;

   // Physical pin roles; the positions are fixed by the routing limits.
   localparam int PIN_COUNT     = 4;
   localparam int PIN_REF       = 0;
   localparam int PIN_CORE_ONLY = 1;
   localparam int PIN_SHARED    = 2;
   localparam int PIN_IO_ONLY   = 3;

   // Number of reachable sources behind every selectable line.
   localparam int SRC_PER_LINE  = 3;

   // Multiplexer implementation variants.
   localparam int MUX_AND_OR    = 0;
   localparam int MUX_PRIORITY  = 1;

   // Candidate vector for a core line: index equals source code.
   function automatic logic [SRC_PER_LINE-1:0] core_candidates(
      input logic [PIN_COUNT-1:0] pins,
      input logic                 gen);
      return {gen, pins[PIN_SHARED], pins[PIN_CORE_ONLY]};
   endfunction

   // Candidate vector for an I/O line: index equals source code.
   function automatic logic [SRC_PER_LINE-1:0] io_candidates(
      input logic [PIN_COUNT-1:0] pins,
      input logic                 gen);
      return {gen, pins[PIN_IO_ONLY], pins[PIN_SHARED]};
   endfunction

endpackage

// File: rtl/clk_sel_check.sv
module clk_sel_check #(
   parameter int N_SRC = 3,
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N_SRC-1:0] grant,
   output logic             illegal
);

   localparam bit HAS_SPARE = ((1 << SEL_W) > N_SRC);

   if (N_SRC < 1) begin : g_bad_nsrc
      $error("clk_sel_check: N_SRC must be at least 1");
   end
   if ((1 << SEL_W) < N_SRC) begin : g_bad_width
      $error("clk_sel_check: SEL_W too narrow for N_SRC");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_grant
      assign grant[i] = (sel == SEL_W'(i));
   end

   if (HAS_SPARE) begin : g_spare
      assign illegal = (sel >= SEL_W'(N_SRC));
   end else begin : g_full
      assign illegal = 1'b0;
   end

   always_comb begin
      AST_ONEHOT_GRANT: assert ($onehot0(grant)) else $error("grant not one-hot"); // R2
      AST_GRANT_OR_FLAG: assert ((|grant) != illegal) else $error("grant and illegal flag disagree"); // R5
   end

endmodule

// File: rtl/clk_src_mux.sv
module clk_src_mux #(
   parameter int N_SRC     = 3,
   parameter int MUX_STYLE = 0
) (
   input  logic [N_SRC-1:0] src,
   input  logic [N_SRC-1:0] grant,
   input  logic             illegal,
   output logic             clk_out
);

   import clkroute_pkg::*;

   if (MUX_STYLE == MUX_AND_OR) begin : g_and_or
      assign clk_out = |(src & grant);
   end else if (MUX_STYLE == MUX_PRIORITY) begin : g_priority
      always_comb begin
         clk_out = 1'b0;
         for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) clk_out = src[i];
         end
      end
   end else begin : g_bad_style
      $error("clk_src_mux: unknown MUX_STYLE");
      assign clk_out = 1'b0;
   end

   always_comb begin
      if (illegal) begin
         AST_DEAD_LINE_LOW: assert (clk_out == 1'b0) else $error("dead line not low"); // R4
      end
   end

endmodule

// File: rtl/clock_route_net.sv
module clock_route_net #(
   parameter int N_CORE_LINES = 3,
   parameter int N_IO_LINES   = 2,
   parameter int SEL_W        = 2,
   parameter int MUX_STYLE    = 0
) (
   input  logic [3:0]                         pin_clk,
   input  logic                               gen_clk,
   input  logic [(N_CORE_LINES-1)*SEL_W-1:0]  core_sel,
   input  logic [N_IO_LINES*SEL_W-1:0]        io_sel,
   output logic [N_CORE_LINES-1:0]            core_clk,
   output logic [N_IO_LINES-1:0]              io_clk,
   output logic                               config_error
);

   import clkroute_pkg::*;

   localparam int N_SEL_CORE = N_CORE_LINES - 1;

   if (N_CORE_LINES < 2) begin : g_bad_core
      $error("clock_route_net: need the reference line plus one selectable core line");
   end
   if (N_IO_LINES < 1) begin : g_bad_io
      $error("clock_route_net: need at least one I/O line");
   end
   if (SEL_W < 2) begin : g_bad_sel
      $error("clock_route_net: SEL_W must encode three sources");
   end

   logic [SRC_PER_LINE-1:0] core_src;
   logic [SRC_PER_LINE-1:0] io_src;
   logic [N_CORE_LINES-1:0] core_bad;
   logic [N_IO_LINES-1:0]   io_bad;

   assign core_src = core_candidates(pin_clk, gen_clk);
   assign io_src   = io_candidates(pin_clk, gen_clk);

   // Reference line: fixed to the reference pin.
   assign core_clk[0] = pin_clk[PIN_REF];
   assign core_bad[0] = 1'b0;

   for (genvar k = 1; k < N_CORE_LINES; k++) begin : g_core
      logic [SRC_PER_LINE-1:0] grant;
      logic                    illegal;

      clk_sel_check #(.N_SRC(SRC_PER_LINE), .SEL_W(SEL_W)) u_chk (
         .sel     (core_sel[(k-1)*SEL_W +: SEL_W]),
         .grant   (grant),
         .illegal (illegal)
      );

      clk_src_mux #(.N_SRC(SRC_PER_LINE), .MUX_STYLE(MUX_STYLE)) u_mux (
         .src     (core_src),
         .grant   (grant),
         .illegal (illegal),
         .clk_out (core_clk[k])
      );

      assign core_bad[k] = illegal;
   end

   for (genvar j = 0; j < N_IO_LINES; j++) begin : g_io
      logic [SRC_PER_LINE-1:0] grant;
      logic                    illegal;

      clk_sel_check #(.N_SRC(SRC_PER_LINE), .SEL_W(SEL_W)) u_chk (
         .sel     (io_sel[j*SEL_W +: SEL_W]),
         .grant   (grant),
         .illegal (illegal)
      );

      clk_src_mux #(.N_SRC(SRC_PER_LINE), .MUX_STYLE(MUX_STYLE)) u_mux (
         .src     (io_src),
         .grant   (grant),
         .illegal (illegal),
         .clk_out (io_clk[j])
      );

      assign io_bad[j] = illegal;
   end

   assign config_error = (|core_bad) | (|io_bad);

   // Reachability guard: with every legal candidate low, no forbidden pin may show.
   always_comb begin
      if (!(pin_clk[PIN_CORE_ONLY] | pin_clk[PIN_SHARED] | gen_clk)) begin
         for (int k = 1; k < N_CORE_LINES; k++) begin
            AST_CORE_NO_FOREIGN: assert (core_clk[k] == 1'b0) else $error("foreign pin on core line"); // R7
         end
      end
      if (!(pin_clk[PIN_SHARED] | pin_clk[PIN_IO_ONLY] | gen_clk)) begin
         for (int j = 0; j < N_IO_LINES; j++) begin
            AST_IO_NO_FOREIGN: assert (io_clk[j] == 1'b0) else $error("foreign pin on I/O line"); // R7
         end
      end
   end

   // Keep N_SEL_CORE referenced for width bookkeeping.
   if (N_SEL_CORE * SEL_W != $bits(core_sel)) begin : g_bad_width
      $error("clock_route_net: core_sel width mismatch");
   end

endmodule

// File: tb/clock_route_net_tb.sv
`timescale 1ns/1ps
module clock_route_net_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic       rst_n;
   logic [3:0] pin_clk;
   logic       gen_clk;
   logic [3:0] core_sel;
   logic [3:0] io_sel;
   logic [2:0] core_clk;
   logic [1:0] io_clk;
   logic       config_error;

   clock_route_net u_dut (
      .pin_clk      (pin_clk),
      .gen_clk      (gen_clk),
      .core_sel     (core_sel),
      .io_sel       (io_sel),
      .core_clk     (core_clk),
      .io_clk       (io_clk),
      .config_error (config_error)
   );

   typedef struct packed {
      logic [2:0] core;
      logic [1:0] io;
      logic       err;
      logic [3:0] ccode;
      logic [3:0] icode;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int   n_vec  = 0;
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   function automatic exp_t model(logic [3:0] p, logic g, logic [3:0] c, logic [3:0] s);
      exp_t e;
      e.ccode = c;
      e.icode = s;
      e.core[0] = p[0];
      e.err = 1'b0;
      for (int k = 1; k < 3; k++) begin
         case (c[2*(k-1) +: 2])
            2'd0: e.core[k] = p[1];
            2'd1: e.core[k] = p[2];
            2'd2: e.core[k] = g;
            default: begin e.core[k] = 1'b0; e.err = 1'b1; end
         endcase
      end
      for (int j = 0; j < 2; j++) begin
         case (s[2*j +: 2])
            2'd0: e.io[j] = p[2];
            2'd1: e.io[j] = p[3];
            2'd2: e.io[j] = g;
            default: begin e.io[j] = 1'b0; e.err = 1'b1; end
         endcase
      end
      return e;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b (core_sel=%b io_sel=%b pins=%b gen=%b)",
                  tag, act, exp, core_sel, io_sel, pin_clk, gen_clk);
      end
   endtask

   task automatic drive(input logic [3:0] p, input logic g, input logic [3:0] c, input logic [3:0] s);
      @(posedge clk);
      pin_clk  = p;
      gen_clk  = g;
      core_sel = c;
      io_sel   = s;
      q.push_back(model(p, g, c, s));
   endtask

   // Scoreboard monitor: compares half a cycle after each drive.
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         cur = q.pop_front();
         n_vec++;
         check(core_clk[0] == cur.core[0], "R1 ref line", {3'b0, core_clk[0]}, {3'b0, cur.core[0]});
         for (int k = 1; k < 3; k++) begin
            check(core_clk[k] == cur.core[k],
                  (cur.ccode[2*(k-1) +: 2] == 2'd3) ? "R4 core dead line" : "R2 core line",
                  {3'b0, core_clk[k]}, {3'b0, cur.core[k]});
         end
         for (int j = 0; j < 2; j++) begin
            check(io_clk[j] == cur.io[j],
                  (cur.icode[2*j +: 2] == 2'd3) ? "R4 io dead line" : "R3 io line",
                  {3'b0, io_clk[j]}, {3'b0, cur.io[j]});
         end
         check(config_error == cur.err, "R5 config_error", {3'b0, config_error}, {3'b0, cur.err});
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      pin_clk  = 4'b0;
      gen_clk  = 1'b0;
      core_sel = 4'b0;
      io_sel   = 4'b0;
      repeat (2) @(posedge clk);
      #5;
      // Idle state with all sources low and legal codes (R1, R5).
      check(core_clk == 3'b000, "R1 idle core lines", {1'b0, core_clk}, 4'b0);
      check(io_clk == 2'b00, "R3 idle io lines", {2'b0, io_clk}, 4'b0);
      check(config_error == 1'b0, "R5 idle flag", {3'b0, config_error}, 4'b0);
      rst_n = 1'b1;

      // Exhaustive: every select setting against every source level (R2 R3 R4 R5 R6).
      for (int c = 0; c < 256; c++) begin
         for (int pt = 0; pt < 32; pt++) begin
            drive(pt[3:0], pt[4], c[3:0], c[7:4]);
         end
      end
      wait (q.size() == 0);
      @(negedge clk);

      // R7: forbidden pins high, legal candidates low, every legal code.
      for (int c = 0; c < 3; c++) begin
         for (int s = 0; s < 3; s++) begin
            core_sel = {c[1:0], c[1:0]};
            io_sel   = {s[1:0], s[1:0]};
            pin_clk  = 4'b1001;
            gen_clk  = 1'b0;
            #2;
            check(core_clk[2:1] == 2'b00, "R7 pins 0/3 kept off core lines", {2'b0, core_clk[2:1]}, 4'b0);
            pin_clk  = 4'b0011;
            #2;
            check(io_clk == 2'b00, "R7 pins 0/1 kept off io lines", {2'b0, io_clk}, 4'b0);
         end
      end

      // R6: distinct codes per field pick distinct sources.
      @(negedge clk);
      pin_clk  = 4'b0000;
      gen_clk  = 1'b1;
      core_sel = 4'b0010;   // line1 code 2 (gen), line2 code 0 (pin 1 = 0)
      io_sel   = 4'b1011;   // io0 code 3 (dead), io1 code 2 (gen)
      #2;
      check(core_clk == 3'b010, "R6 core field positions", {1'b0, core_clk}, 4'b0010);
      check(io_clk == 2'b10, "R6 io field positions", {2'b0, io_clk}, 4'b0010);
      check(config_error == 1'b1, "R6 flag from io0 field", {3'b0, config_error}, 4'b0001);

      // R8: mid-phase changes appear with no clock edge.
      @(negedge clk);
      core_sel = 4'b1010;
      io_sel   = 4'b1010;
      gen_clk  = 1'b1;
      #1;
      check(core_clk[2:1] == 2'b11 && io_clk == 2'b11, "R8 follows gen high",
            {core_clk[2:1], io_clk}, 4'b1111);
      gen_clk = 1'b0;
      #1;
      check(core_clk[2:1] == 2'b00 && io_clk == 2'b00, "R8 follows gen low",
            {core_clk[2:1], io_clk}, 4'b0000);
      pin_clk = 4'b0001;
      #1;
      check(core_clk[0] == 1'b1, "R8 R1 ref follows pin 0", {3'b0, core_clk[0]}, 4'b0001);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule